// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block carries out one two-operand addition whose source operand may be located in any of ten ways. A decoded instruction arrives with a one-cycle `start` strobe. It carries:

- a 4-bit mode code;
- a destination register index;
- two source register indices (a base and an index);
- a signed displacement;
- a 32-bit constant that serves as an immediate value or as an absolute address.

The unit holds its own register file. From it the unit forms an effective address and fetches the operand through a single-word read port whose data may return after any number of cycles. It then writes the destination with destination plus operand.

Some modes need more than one step, and each sequences its own cycles:

- pointer-through-memory mode reads memory twice;
- post-increment mode advances the base register after its read;
- pre-decrement mode steps the base register back before its read;
- scaled mode adds the index register multiplied by the element size.

The block is meant to sit behind a decoder in a small core or a test engine. The caller waits for `done` before it issues the next instruction. A `start` received while the unit is busy is dropped.

Top module: `opfetch_unit`

## Requirements
- R1: Mode 0 (register) writes Rd <- Rd + R[rb_sel] and issues no memory request.
- R2: Mode 1 (immediate) writes Rd <- Rd + const_in and issues no memory request.
- R3: Mode 2 (displacement) issues one read at R[rb_sel] + sign-extended disp_in and adds the returned word to Rd.
- R4: Mode 3 (register indirect) issues one read at R[rb_sel] and adds the returned word to Rd.
- R5: Mode 4 (indexed) issues one read at R[rb_sel] + R[ri_sel] and adds the returned word to Rd.
- R6: Mode 5 (absolute) issues one read at const_in and adds the returned word to Rd.
- R7: Mode 6 (memory indirect) issues a read at R[rb_sel], then a second read at the word returned, and adds the second returned word to Rd.
- R8: Mode 7 (post-increment) reads at the old R[rb_sel], then writes R[rb_sel] <- old value + 4.
- R9: Mode 8 (pre-decrement) writes R[rb_sel] <- R[rb_sel] - 4 first, then reads at the new value and adds the word to the Rd value as seen after that update.
- R10: Mode 9 (scaled) issues one read at R[rb_sel] + sign-extended disp_in + 4 * R[ri_sel].
- R11: Codes 10 to 15 raise `illegal` for one cycle, exactly one cycle after the accepted `start`, with no memory request and no register change.
- R12: `done` is a single-cycle pulse in the cycle after all writes land, and a `start` given while `busy` is high is ignored.
- R13: When the destination and the base register are the same register, the destination holds the addition result at the end.
- R14: After reset all eight registers read zero, and `busy`, `done`, `illegal` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the instruction on the inputs (only when idle) |
| mode_in | input | 4 | Addressing mode code |
| rd_sel | input | 3 | Destination register index |
| rb_sel | input | 3 | Base register index (source register in mode 0) |
| ri_sel | input | 3 | Index register index |
| disp_in | input | 16 | Signed displacement |
| const_in | input | 32 | Immediate value or absolute address |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse once all register writes are complete |
| illegal | output | 1 | One-cycle pulse for an unsupported mode code |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the unit with its default parameters: eight 32-bit registers, a 4-byte element and a 16-bit displacement.

With three-bit register indices, random instructions often pick the same register for destination, base and index. That reaches the ordering cases of R9 and R13 without special steering. The 16-bit displacement lets negative offsets and 32-bit address wrap occur.

Register contents are read back through register-indirect probes whose returned data is zero. The probe's request address then exposes the register value, and the probe leaves the register file unchanged.

// File: rtl/opf_pkg.sv
package opf_pkg;

   localparam logic [3:0] MD_REG     = 4'd0;
   localparam logic [3:0] MD_IMM     = 4'd1;
   localparam logic [3:0] MD_DISP    = 4'd2;
   localparam logic [3:0] MD_RIND    = 4'd3;
   localparam logic [3:0] MD_IDX     = 4'd4;
   localparam logic [3:0] MD_ABS     = 4'd5;
   localparam logic [3:0] MD_MIND    = 4'd6;
   localparam logic [3:0] MD_POSTINC = 4'd7;
   localparam logic [3:0] MD_PREDEC  = 4'd8;
   localparam logic [3:0] MD_SCALED  = 4'd9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_REQ,
      ST_WAIT,
      ST_EXEC
   } seq_state_e;

   function automatic logic mode_legal(input logic [3:0] m);
      return m <= MD_SCALED;
   endfunction

   function automatic logic mode_no_mem(input logic [3:0] m);
      return (m == MD_REG) || (m == MD_IMM);
   endfunction

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
   parameter int NREGS = 8,
   parameter int DW    = 32,
   localparam int IW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   input  logic [IW-1:0] rb_idx,
   input  logic [IW-1:0] ri_idx,
   output logic [DW-1:0] rd_val,
   output logic [DW-1:0] rb_val,
   output logic [DW-1:0] ri_val,
   input  logic          wb_en,
   input  logic [IW-1:0] wb_idx,
   input  logic [DW-1:0] wb_dat,
   input  logic          wd_en,
   input  logic [IW-1:0] wd_idx,
   input  logic [DW-1:0] wd_dat
);

   generate
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("opf_regfile: NREGS must be a power of two, at least 2");
      end
      if (DW < 8) begin : g_bad_dw
         $error("opf_regfile: DW too small");
      end
   endgenerate

   logic [DW-1:0] regs [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NREGS; k++) regs[k] <= '0;
      end else begin
         for (int k = 0; k < NREGS; k++) begin
            if (wd_en && wd_idx == IW'(k))
               regs[k] <= wd_dat;
            else if (wb_en && wb_idx == IW'(k))
               regs[k] <= wb_dat;
         end
      end
   end

   assign rd_val = regs[rd_idx];
   assign rb_val = regs[rb_idx];
   assign ri_val = regs[ri_idx];

   logic          coll_q;
   logic [IW-1:0] coll_idx_q;
   logic [DW-1:0] coll_dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coll_q     <= 1'b0;
         coll_idx_q <= '0;
         coll_dat_q <= '0;
      end else begin
         coll_q     <= wd_en && wb_en && (wd_idx == wb_idx);
         coll_idx_q <= wd_idx;
         coll_dat_q <= wd_dat;
      end
   end

   // R13
   dest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coll_q |-> (regs[coll_idx_q] == coll_dat_q));

endmodule

// File: rtl/opf_agu.sv
module opf_agu #(
   parameter int DW         = 32,
   parameter int DISPW      = 16,
   parameter int ELEM_BYTES = 4
) (
   input  logic [3:0]       mode,
   input  logic [DW-1:0]    base,
   input  logic [DW-1:0]    index,
   input  logic [DISPW-1:0] disp,
   input  logic [DW-1:0]    abs_addr,
   output logic [DW-1:0]    ea
);
   import opf_pkg::*;

   localparam int ESHIFT = (ELEM_BYTES > 1) ? $clog2(ELEM_BYTES) : 0;
   localparam bit EPOW2  = (ELEM_BYTES & (ELEM_BYTES - 1)) == 0;

   generate
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("opf_agu: ELEM_BYTES must be positive");
      end
      if (DISPW < 1 || DISPW >= DW) begin : g_bad_disp
         $error("opf_agu: DISPW must be between 1 and DW-1");
      end
   endgenerate

   logic [DW-1:0] disp_x;
   logic [DW-1:0] scaled;

   assign disp_x = {{(DW - DISPW){disp[DISPW-1]}}, disp};

   generate
      if (EPOW2) begin : g_shift_scale
         assign scaled = index << ESHIFT;
      end else begin : g_mul_scale
         assign scaled = index * DW'(ELEM_BYTES);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MD_DISP:   ea = base + disp_x;
         MD_IDX:    ea = base + index;
         MD_ABS:    ea = abs_addr;
         MD_SCALED: ea = base + disp_x + scaled;
         default:   ea = base;
      endcase
   end

endmodule

// File: rtl/opf_seq.sv
module opf_seq #(
   parameter int NREGS      = 8,
   parameter int DW         = 32,
   parameter int DISPW      = 16,
   parameter int ELEM_BYTES = 4,
   localparam int IW        = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       mode_in,
   input  logic [IW-1:0]    rd_in,
   input  logic [IW-1:0]    rb_in,
   input  logic [IW-1:0]    ri_in,
   input  logic [DISPW-1:0] disp_in,
   input  logic [DW-1:0]    const_in,
   output logic [3:0]       mode_q,
   output logic [IW-1:0]    rd_q,
   output logic [IW-1:0]    rb_q,
   output logic [IW-1:0]    ri_q,
   output logic [DISPW-1:0] disp_q,
   output logic [DW-1:0]    const_q,
   input  logic [DW-1:0]    rd_val,
   input  logic [DW-1:0]    rb_val,
   input  logic [DW-1:0]    ea,
   output logic             wb_en,
   output logic [DW-1:0]    wb_dat,
   output logic             wd_en,
   output logic [DW-1:0]    wd_dat,
   output logic             mem_req,
   output logic [DW-1:0]    mem_addr,
   input  logic             mem_rvalid,
   input  logic [DW-1:0]    mem_rdata,
   output logic             busy,
   output logic             done,
   output logic             illegal
);
   import opf_pkg::*;

   localparam logic [DW-1:0] STEP = DW'(ELEM_BYTES);

   seq_state_e    state, nstate;
   logic          second_q;
   logic [DW-1:0] ptr_q;
   logic [DW-1:0] opnd_q;
   logic          done_q, ill_q;
   logic [DW-1:0] operand;

   always_comb begin
      nstate = state;
      unique case (state)
         ST_IDLE:
            if (start && mode_legal(mode_in)) begin
               if (mode_in == MD_PREDEC)      nstate = ST_PRE;
               else if (mode_no_mem(mode_in)) nstate = ST_EXEC;
               else                           nstate = ST_REQ;
            end
         ST_PRE:  nstate = ST_REQ;
         ST_REQ:  nstate = ST_WAIT;
         ST_WAIT:
            if (mem_rvalid)
               nstate = (mode_q == MD_MIND && !second_q) ? ST_REQ : ST_EXEC;
         ST_EXEC: nstate = ST_IDLE;
         default: nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= '0;
         rd_q     <= '0;
         rb_q     <= '0;
         ri_q     <= '0;
         disp_q   <= '0;
         const_q  <= '0;
         second_q <= 1'b0;
         ptr_q    <= '0;
         opnd_q   <= '0;
         done_q   <= 1'b0;
         ill_q    <= 1'b0;
      end else begin
         state  <= nstate;
         done_q <= (state == ST_EXEC);
         ill_q  <= (state == ST_IDLE) && start && !mode_legal(mode_in);
         if (state == ST_IDLE && start && mode_legal(mode_in)) begin
            mode_q   <= mode_in;
            rd_q     <= rd_in;
            rb_q     <= rb_in;
            ri_q     <= ri_in;
            disp_q   <= disp_in;
            const_q  <= const_in;
            second_q <= 1'b0;
         end
         if (state == ST_WAIT && mem_rvalid) begin
            if (mode_q == MD_MIND && !second_q) begin
               ptr_q    <= mem_rdata;
               second_q <= 1'b1;
            end else begin
               opnd_q <= mem_rdata;
            end
         end
      end
   end

   always_comb begin
      unique case (mode_q)
         MD_REG:  operand = rb_val;
         MD_IMM:  operand = const_q;
         default: operand = opnd_q;
      endcase
   end

   // Base update: pre-step in ST_PRE, post-step alongside the result.
   always_comb begin
      wb_en  = 1'b0;
      wb_dat = rb_val + STEP;
      if (state == ST_PRE) begin
         wb_en  = 1'b1;
         wb_dat = rb_val - STEP;
      end else if (state == ST_EXEC && mode_q == MD_POSTINC) begin
         wb_en  = 1'b1;
      end
   end

   assign wd_en    = (state == ST_EXEC);
   assign wd_dat   = rd_val + operand;
   assign mem_req  = (state == ST_REQ);
   assign mem_addr = second_q ? ptr_q : ea;
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign illegal  = ill_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !mem_req && !done));

   // R1
   no_mem_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mode_no_mem(mode_q));

   // R7
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R9
   predec_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |=> mem_req);

   // R8
   postinc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && state == ST_EXEC) |-> (mode_q == MD_POSTINC && wd_en));

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
   parameter int NREGS      = 8,
   parameter int DW         = 32,
   parameter int DISPW      = 16,
   parameter int ELEM_BYTES = 4,
   localparam int IW        = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       mode_in,
   input  logic [IW-1:0]    rd_sel,
   input  logic [IW-1:0]    rb_sel,
   input  logic [IW-1:0]    ri_sel,
   input  logic [DISPW-1:0] disp_in,
   input  logic [DW-1:0]    const_in,
   output logic             busy,
   output logic             done,
   output logic             illegal,
   output logic             mem_req,
   output logic [DW-1:0]    mem_addr,
   input  logic             mem_rvalid,
   input  logic [DW-1:0]    mem_rdata
);

   logic [3:0]       mode_q;
   logic [IW-1:0]    rd_q, rb_q, ri_q;
   logic [DISPW-1:0] disp_q;
   logic [DW-1:0]    const_q;
   logic [DW-1:0]    rd_val, rb_val, ri_val, ea;
   logic             wb_en, wd_en;
   logic [DW-1:0]    wb_dat, wd_dat;

   opf_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rd_q),
      .rb_idx (rb_q),
      .ri_idx (ri_q),
      .rd_val (rd_val),
      .rb_val (rb_val),
      .ri_val (ri_val),
      .wb_en  (wb_en),
      .wb_idx (rb_q),
      .wb_dat (wb_dat),
      .wd_en  (wd_en),
      .wd_idx (rd_q),
      .wd_dat (wd_dat)
   );

   opf_agu #(.DW(DW), .DISPW(DISPW), .ELEM_BYTES(ELEM_BYTES)) u_agu (
      .mode     (mode_q),
      .base     (rb_val),
      .index    (ri_val),
      .disp     (disp_q),
      .abs_addr (const_q),
      .ea       (ea)
   );

   opf_seq #(.NREGS(NREGS), .DW(DW), .DISPW(DISPW), .ELEM_BYTES(ELEM_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode_in    (mode_in),
      .rd_in      (rd_sel),
      .rb_in      (rb_sel),
      .ri_in      (ri_sel),
      .disp_in    (disp_in),
      .const_in   (const_in),
      .mode_q     (mode_q),
      .rd_q       (rd_q),
      .rb_q       (rb_q),
      .ri_q       (ri_q),
      .disp_q     (disp_q),
      .const_q    (const_q),
      .rd_val     (rd_val),
      .rb_val     (rb_val),
      .ea         (ea),
      .wb_en      (wb_en),
      .wb_dat     (wb_dat),
      .wd_en      (wd_en),
      .wd_dat     (wd_dat),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .busy       (busy),
      .done       (done),
      .illegal    (illegal)
   );

endmodule

// File: tb/opfetch_unit_test.sv
module opfetch_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode_in = '0;
   logic [2:0]  rd_sel = '0, rb_sel = '0, ri_sel = '0;
   logic [15:0] disp_in = '0;
   logic [31:0] const_in = '0;
   logic        busy, done, illegal, mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int vectors = 0;
   int fails = 0;
   bit zero_mem = 1'b0;
   logic [31:0] rm [8];

   always #5 clk = ~clk;

   opfetch_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
      .rd_sel(rd_sel), .rb_sel(rb_sel), .ri_sel(ri_sel),
      .disp_in(disp_in), .const_in(const_in),
      .busy(busy), .done(done), .illegal(illegal),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      if (zero_mem) return 32'h0;
      return (a ^ 32'h3C5A96E1) * 32'h0001_0193 + 32'h11;
   endfunction

   function automatic logic [31:0] sx(input logic [15:0] d);
      return {{16{d[15]}}, d};
   endfunction

   function automatic string mtag(input logic [3:0] m);
      case (m)
         4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
         4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
         4'd6: return "R7";  4'd7: return "R8";  4'd8: return "R9";
         4'd9: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tg, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] m, input logic [2:0] d, input logic [2:0] b,
                      input logic [2:0] i, input logic [15:0] dp, input logic [31:0] im,
                      input bit poke, input string tgo);
      logic [31:0] a1, a2, op, rdo;
      int nexp, nreq, n, lat;
      bit legal, seen_done, seen_ill;
      string tg;
      tg = (tgo == "") ? mtag(m) : tgo;
      legal = (m <= 4'd9);
      a1 = '0; a2 = '0; op = '0;
      case (m)
         4'd2: a1 = rm[b] + sx(dp);
         4'd3: a1 = rm[b];
         4'd4: a1 = rm[b] + rm[i];
         4'd5: a1 = im;
         4'd6: begin a1 = rm[b]; a2 = memf(a1); end
         4'd7: a1 = rm[b];
         4'd8: a1 = rm[b] - 32'd4;
         4'd9: a1 = rm[b] + sx(dp) + (rm[i] << 2);
         default: a1 = '0;
      endcase
      nexp = (!legal || m <= 4'd1) ? 0 : ((m == 4'd6) ? 2 : 1);
      case (m)
         4'd0: op = rm[b];
         4'd1: op = im;
         4'd6: op = memf(a2);
         default: op = memf(a1);
      endcase
      if (legal) begin
         if (m == 4'd8) rm[b] = rm[b] - 32'd4;
         rdo = rm[d];
         if (m == 4'd7) rm[b] = rm[b] + 32'd4;
         rm[d] = rdo + op;
      end
      @(negedge clk);
      mode_in = m; rd_sel = d; rb_sel = b; ri_sel = i; disp_in = dp; const_in = im;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nreq = 0; n = 0; seen_done = 0; seen_ill = 0;
      while (n < 80) begin
         if (done) begin seen_done = 1; break; end
         if (illegal) begin seen_ill = 1; break; end
         if (mem_req) begin
            chk(mem_addr == ((nreq == 0) ? a1 : a2), tg, "read address", mem_addr,
                (nreq == 0) ? a1 : a2);
            nreq++;
            if (poke) begin mode_in = 4'hF; start = 1'b1; end
            lat = 1 + int'($urandom % 3);
            for (int k = 0; k < lat; k++) begin
               @(negedge clk);
               start = 1'b0;
            end
            mem_rvalid = 1'b1;
            mem_rdata = memf(mem_addr == a1 && nreq == 1 ? a1 : a2);
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata = '0;
         end else begin
            @(negedge clk);
         end
         n++;
      end
      chk(nreq == nexp, tg, "request count", nreq, nexp);
      if (legal) chk(seen_done && !seen_ill, tg, "done pulse", {30'd0, seen_ill, seen_done}, 32'd1);
      else chk(seen_ill && !seen_done, tg, "illegal pulse", {30'd0, seen_ill, seen_done}, 32'd2);
      if (poke) chk(!seen_ill, "R12", "start while busy", {31'd0, seen_ill}, 32'd0);
      if (seen_done || seen_ill) begin
         @(negedge clk);
         chk(!done && !illegal, tg, "pulse width", {30'd0, done, illegal}, 32'd0);
      end
   endtask

   task automatic probe(input logic [2:0] x, input string tg);
      zero_mem = 1'b1;
      run(4'd3, 3'd0, x, 3'd0, 16'd0, 32'd0, 1'b0, tg);
      zero_mem = 1'b0;
   endtask

   task automatic dump(input string tg);
      for (int k = 0; k < 8; k++) probe(3'(k), tg);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int k = 0; k < 8; k++) rm[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk(!busy && !done && !illegal && !mem_req, "R14", "idle outputs",
          {28'd0, busy, done, illegal, mem_req}, 32'd0);
      dump("R14");
      // R2 load registers through immediate adds
      for (int k = 0; k < 8; k++)
         run(4'd1, 3'(k), 3'd0, 3'd0, 16'd0, 32'h1000 * (k + 1) + 32'h10, 1'b0, "");
      dump("R2");
      // R1 register source
      run(4'd0, 3'd2, 3'd5, 3'd0, 16'd0, 32'd0, 1'b0, "");
      run(4'd0, 3'd3, 3'd3, 3'd0, 16'd0, 32'd0, 1'b0, "");
      // R3 negative and positive displacement
      run(4'd2, 3'd1, 3'd4, 3'd0, 16'hFFF0, 32'd0, 1'b0, "");
      run(4'd2, 3'd6, 3'd0, 3'd0, 16'h7FFC, 32'd0, 1'b0, "");
      run(4'd3, 3'd7, 3'd2, 3'd0, 16'd0, 32'd0, 1'b0, "");   // R4
      run(4'd4, 3'd0, 3'd1, 3'd5, 16'd0, 32'd0, 1'b0, "");   // R5
      run(4'd5, 3'd4, 3'd0, 3'd0, 16'd0, 32'hDEAD_BEE0, 1'b0, ""); // R6
      run(4'd6, 3'd5, 3'd6, 3'd0, 16'd0, 32'd0, 1'b0, "");   // R7
      run(4'd7, 3'd2, 3'd3, 3'd0, 16'd0, 32'd0, 1'b0, "");   // R8
      run(4'd8, 3'd1, 3'd3, 3'd0, 16'd0, 32'd0, 1'b0, "");   // R9
      run(4'd9, 3'd0, 3'd7, 3'd6, 16'hFF00, 32'd0, 1'b0, ""); // R10
      dump("R8");
      // R13 destination equals base
      run(4'd7, 3'd4, 3'd4, 3'd0, 16'd0, 32'd0, 1'b0, "R13");
      run(4'd8, 3'd6, 3'd6, 3'd0, 16'd0, 32'd0, 1'b0, "R13");
      probe(3'd4, "R13");
      probe(3'd6, "R13");
      // R11 illegal codes leave registers untouched
      run(4'd10, 3'd1, 3'd2, 3'd3, 16'd4, 32'd5, 1'b0, "");
      run(4'd15, 3'd7, 3'd7, 3'd7, 16'd0, 32'd9, 1'b0, "");
      dump("R11");
      // R12 start ignored while busy
      run(4'd2, 3'd3, 3'd5, 3'd0, 16'd8, 32'd0, 1'b1, "R12");
      run(4'd6, 3'd0, 3'd1, 3'd0, 16'd0, 32'd0, 1'b1, "R12");
      dump("R12");
      // constrained random mix
      for (int t = 0; t < 400; t++) begin
         logic [3:0] m;
         logic [2:0] d, b;
         m = 4'($urandom % 12);
         d = 3'($urandom % 8);
         b = ($urandom % 4 == 0) ? d : 3'($urandom % 8);
         run(m, d, b, 3'($urandom % 8), 16'($urandom), $urandom, 1'b0, "");
         probe(d, mtag(m));
         probe(b, mtag(m));
      end
      dump("R13");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule